// File: doc/BRIEF.md
# Random Address Tag Insertion Unit

This block places a 4-bit tag into a 64-bit address. The tag is chosen pseudo-randomly from the sixteen possible values and never takes a value that is barred by the exclusion set. Each request carries two operands: an address and an exclusion operand. The exclusion operand is combined with a configured 16-bit mask, and a bit set in the result removes the matching tag value from the choice. A 16-bit linear feedback shift register supplies the randomness.

Two selection policies exist. In free mode a random draw is moved upward to the nearest allowed value. In sequential mode a stored previous tag is the starting point, and a random offset counts how many allowed values to step past. The chosen tag is then stored as the next starting point. A tag-access enable forces the tag to zero and freezes all state. A seed write port loads the generator and the stored tag. Results are registered, so each result appears one clock after its request, and a new request can be accepted on every cycle.

Top module: `tag_insert_unit`

## Requirements
- R1: The effective exclusion set is `req_excl[15:0] | cfg_excl_mask`. Bit i set means tag value i may not be chosen. Bits 63:16 of `req_excl` have no effect, and a zero operand leaves only the configured mask.
- R2: With `cfg_tag_en` low, the inserted tag is 0000. Neither the generator state nor the stored tag changes.
- R3: If all 16 exclusion bits are set and the enable is high, the tag is 0000 in both modes. In sequential mode the value 0000 is also stored as the next start.
- R4: Free mode (`cfg_seq_mode`=0) draws d = generator state bits 3:0, taken before the generator advances. The tag is d if d is allowed. Otherwise it is the first allowed value found from d+1 upward, modulo 16.
- R5: Sequential mode (`cfg_seq_mode`=1) starts from the stored tag s and uses offset o = generator bits 3:0. When o is 0, the tag is s if s is allowed, and otherwise the next allowed value above s. When o is not 0, o steps are taken from s, and each step moves to the next allowed value modulo 16.
- R6: An enabled sequential request stores its chosen tag as the next start. A free-mode request leaves the stored tag unchanged.
- R7: Result bits 59:56 carry the tag. All other result bits equal the address operand.
- R8: `rsp_valid` rises exactly one clock after each cycle with `req_valid` high, and stays low otherwise. Back-to-back requests give back-to-back results.
- R9: The generator advances once per request that has the enable high. Its next state is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`.
- R10: A seed write loads `seed_lfsr` into the generator and `seed_tag` into the stored tag. A zero seed is replaced by 16'h0001, so the generator is never all zeros.
- R11: After reset, `rsp_valid` and `rsp_data` are zero, the generator holds 16'hACE1 and the stored tag is 0000.
- R12: A request in the same cycle as a seed write uses the old generator state and the old stored tag. The seed values take priority over that request's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Address operand |
| req_excl | input | 64 | Exclusion operand (low 16 bits used) |
| cfg_excl_mask | input | 16 | Configured exclusion mask |
| cfg_seq_mode | input | 1 | 1 = sequential from stored tag, 0 = free random |
| cfg_tag_en | input | 1 | Tag-access enable |
| seed_we | input | 1 | Seed write strobe |
| seed_lfsr | input | 16 | Generator seed value |
| seed_tag | input | 4 | Stored-tag seed value |
| rsp_valid | output | 1 | Result strobe |
| rsp_data | output | 64 | Tagged address |

## Verification
The bench drives masks that leave exactly one tag open, with that one tag coming from the operand alone, from the mask alone, or from both together. A design that ignored either source, or read operand bits above 15, would return a tag other than the single open value. It covers the all-excluded case in both modes, a zero sequential offset with the start excluded and with it allowed, and a zero seed. A design that got these wrong would produce a nonzero tag, stay on an excluded start, or lock the generator at zero. It also checks that disabled and free requests freeze the right state, and it issues a seed and a request in the same cycle. A design that got these wrong would produce later tags that drift away from the reference sequence.

// File: rtl/tagins_pkg.sv
// Package: shared helpers for the tag insertion unit.
// Assumes tags are small (2**TAG_W values) so a linear scan is cheap.
package tagins_pkg;

    // Return the first tag above t (wrapping) whose exclusion bit is clear;
    // returns t itself if only t is allowed, t if none are (caller filters).
    function automatic logic [3:0] next_allowed(input logic [3:0] t,
                                                input logic [15:0] ex);
        logic [3:0] r;
        logic [3:0] c;
        logic       found;
        r     = t;
        found = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            c = t + i[3:0];
            if (!found && !ex[c]) begin
                r     = c;
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tagins_lfsr.sv
// Module: Fibonacci LFSR used as the random source.
// Advances one step when adv is high; load has priority and a zero load
// value is replaced by 1 so the register never locks at all zeros.
module tagins_lfsr #(
    parameter int          W     = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] RST  = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         fb;
    logic [W-1:0] safe_load;

    // Feedback bit from the tapped positions.
    always_comb fb = ^(state & TAPS);

    // Zero-seed substitution.
    always_comb safe_load = (load_val == '0) ? ONE : load_val;

    // State register: reset, seed load, or shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RST;
        else if (load)
            state <= safe_load;
        else if (adv)
            state <= {state[W-2:0], fb};
    end
endmodule

// File: rtl/tagins_free_pick.sv
// Module: free-random tag choice.
// Takes a raw random draw; if it is excluded, moves upward to the first
// allowed value. Fully excluded set yields zero. Purely combinational.
module tagins_free_pick #(
    parameter int TAG_W = 4,
    localparam int NT   = 1 << TAG_W
) (
    input  logic [TAG_W-1:0] draw,
    input  logic [NT-1:0]    ex,
    output logic [TAG_W-1:0] tag
);
    import tagins_pkg::*;

    // Select draw, its next allowed neighbour, or zero.
    always_comb begin
        if (&ex)
            tag = '0;
        else if (ex[draw])
            tag = next_allowed(draw, ex);
        else
            tag = draw;
    end
endmodule

// File: rtl/tagins_seq_pick.sv
// Module: sequential tag choice from a start value plus a random offset.
// Builds an unrolled chain of NT-1 "next allowed" stages; stage k steps
// only when k <= offset. Zero offset with an excluded start takes one step.
module tagins_seq_pick #(
    parameter int TAG_W = 4,
    localparam int NT   = 1 << TAG_W
) (
    input  logic [TAG_W-1:0] start,
    input  logic [TAG_W-1:0] offset,
    input  logic [NT-1:0]    ex,
    output logic [TAG_W-1:0] tag
);
    import tagins_pkg::*;

    logic [TAG_W-1:0] chain [NT];

    // Stage 0: fix up an excluded start when the offset is zero.
    always_comb begin
        if (offset == '0 && ex[start])
            chain[0] = next_allowed(start, ex);
        else
            chain[0] = start;
    end

    // Stages 1..NT-1: conditional steps to the next allowed value.
    for (genvar k = 1; k < NT; k++) begin : g_step
        always_comb begin
            if (32'(offset) >= k)
                chain[k] = next_allowed(chain[k-1], ex);
            else
                chain[k] = chain[k-1];
        end
    end

    // Final choice; fully excluded set yields zero.
    always_comb tag = (&ex) ? '0 : chain[NT-1];
endmodule

// File: rtl/tag_insert_unit.sv
// Module: random address tag insertion unit (top).
// Merges the exclusion sources, picks a tag by the selected policy, writes
// it into the tag field of the address and registers the result (1 cycle).
// Assumes the caller holds the configuration inputs valid with req_valid.
module tag_insert_unit #(
    parameter int ADDR_W  = 64,
    parameter int TAG_W   = 4,
    parameter int TAG_LSB = 56,
    parameter int LFSR_W  = 16,
    localparam int NT     = 1 << TAG_W,
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_excl,
    input  logic [NT-1:0]     cfg_excl_mask,
    input  logic              cfg_seq_mode,
    input  logic              cfg_tag_en,
    input  logic              seed_we,
    input  logic [LFSR_W-1:0] seed_lfsr,
    input  logic [TAG_W-1:0]  seed_tag,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_data
);
    logic [NT-1:0]     eff_ex;
    logic [LFSR_W-1:0] lfsr_state;
    logic [TAG_W-1:0]  rnd;
    logic [TAG_W-1:0]  last_tag;
    logic [TAG_W-1:0]  free_tag;
    logic [TAG_W-1:0]  seq_tag;
    logic [TAG_W-1:0]  sel_tag;
    logic [ADDR_W-1:0] merged;
    logic              take;
    logic              unused_excl_hi;
    logic              unused_lfsr_hi;

    // Combine the per-request and configured exclusion sets.
    always_comb eff_ex = req_excl[NT-1:0] | cfg_excl_mask;

    // Bits that play no part in the choice.
    always_comb unused_excl_hi = ^req_excl[ADDR_W-1:NT];
    always_comb unused_lfsr_hi = ^lfsr_state[LFSR_W-1:TAG_W];

    // An enabled request consumes randomness and may update state.
    always_comb take = req_valid && cfg_tag_en;

    always_comb rnd = lfsr_state[TAG_W-1:0];

    tagins_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (take),
        .load     (seed_we),
        .load_val (seed_lfsr),
        .state    (lfsr_state)
    );

    tagins_free_pick #(.TAG_W(TAG_W)) u_free (
        .draw (rnd),
        .ex   (eff_ex),
        .tag  (free_tag)
    );

    tagins_seq_pick #(.TAG_W(TAG_W)) u_seq (
        .start  (last_tag),
        .offset (rnd),
        .ex     (eff_ex),
        .tag    (seq_tag)
    );

    // Policy and enable select the inserted tag.
    always_comb begin
        if (!cfg_tag_en)
            sel_tag = '0;
        else if (cfg_seq_mode)
            sel_tag = seq_tag;
        else
            sel_tag = free_tag;
    end

    // Replace only the tag field of the address.
    always_comb begin
        merged                  = req_addr;
        merged[TAG_MSB:TAG_LSB] = sel_tag;
    end

    // Output register and stored-tag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            last_tag  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid)
                rsp_data <= merged;
            if (seed_we)
                last_tag <= seed_tag;
            else if (take && cfg_seq_mode)
                last_tag <= seq_tag;
        end
    end
endmodule

// File: rtl/tagins_checker.sv
// Module: assertion checker bound to tag_insert_unit.
// Tracks the exclusion set and enable of the last request and checks the
// registered result against them.
module tagins_checker #(
    parameter int ADDR_W  = 64,
    parameter int TAG_W   = 4,
    parameter int TAG_LSB = 56,
    parameter int LFSR_W  = 16,
    localparam int NT     = 1 << TAG_W,
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [NT-1:0]     excl_lo,
    input logic [NT-1:0]     cfg_excl_mask,
    input logic              cfg_tag_en,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_data,
    input logic [LFSR_W-1:0] lfsr_state
);
    logic [NT-1:0] ex_d;
    logic          en_d;
    logic [TAG_W-1:0] rsp_tag;

    // Remember the exclusion set and enable of the latest request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_d <= '0;
            en_d <= 1'b0;
        end else if (req_valid) begin
            ex_d <= excl_lo | cfg_excl_mask;
            en_d <= cfg_tag_en;
        end
    end

    always_comb rsp_tag = rsp_data[TAG_MSB:TAG_LSB];

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_data[TAG_LSB-1:0] == $past(req_addr[TAG_LSB-1:0]) &&
                       rsp_data[ADDR_W-1:TAG_MSB+1] == $past(req_addr[ADDR_W-1:TAG_MSB+1])));

    // R2
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_tag_en) |=> (rsp_tag == '0));

    // R1
    allowed_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && en_d && !(&ex_d)) |-> !ex_d[rsp_tag]);

    // R3
    all_excl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (&ex_d)) |-> (rsp_tag == '0));

    // R10
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);
endmodule

bind tag_insert_unit tagins_checker #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W),
    .TAG_LSB(TAG_LSB),
    .LFSR_W (LFSR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .excl_lo      (req_excl[NT-1:0]),
    .cfg_excl_mask(cfg_excl_mask),
    .cfg_tag_en   (cfg_tag_en),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .lfsr_state   (lfsr_state)
);

// File: tb/tag_insert_unit_test.sv
// Scoreboard bench: the driver pushes expected results computed by a
// reference model; a monitor pops and compares them one cycle later.
module tag_insert_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_excl = '0;
    logic [15:0] cfg_excl_mask = '0;
    logic        cfg_seq_mode = 1'b0;
    logic        cfg_tag_en = 1'b1;
    logic        seed_we = 1'b0;
    logic [15:0] seed_lfsr = '0;
    logic [3:0]  seed_tag = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;

    int checks = 0;
    int errors = 0;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    // Reference model state
    logic [15:0] m_lfsr = 16'hACE1;
    logic [3:0]  m_last = 4'h0;

    always #5 clk = ~clk;

    tag_insert_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_excl(req_excl), .cfg_excl_mask(cfg_excl_mask),
        .cfg_seq_mode(cfg_seq_mode), .cfg_tag_en(cfg_tag_en),
        .seed_we(seed_we), .seed_lfsr(seed_lfsr), .seed_tag(seed_tag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [3:0] m_step(input logic [3:0] t, input logic [15:0] ex);
        logic [3:0] c;
        c = t;
        for (int i = 0; i < 16; i++) begin
            c = c + 4'd1;
            if (!ex[c]) return c;
        end
        return t;
    endfunction

    function automatic logic [15:0] m_adv(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    // Driver: drive a request (optionally with a seed write), model it, push.
    task automatic send(input logic [63:0] a, input logic [63:0] xo,
                        input logic [15:0] mk, input logic sq, input logic en,
                        input logic sw, input logic [15:0] sl, input logic [3:0] st,
                        input string r);
        logic [15:0] ex;
        logic [3:0]  d;
        logic [3:0]  t;
        logic [63:0] e;
        ex = xo[15:0] | mk;
        d  = m_lfsr[3:0];
        if (!en) t = 4'h0;
        else if (ex == 16'hFFFF) t = 4'h0;
        else if (!sq) t = ex[d] ? m_step(d, ex) : d;
        else begin
            t = m_last;
            if (d == 4'h0) begin
                if (ex[t]) t = m_step(t, ex);
            end else begin
                for (int k = 0; k < 16; k++) if (k < int'(d)) t = m_step(t, ex);
            end
        end
        e = a;
        e[59:56] = t;
        exp_q.push_back(e);
        tag_q.push_back(r);
        if (en) begin
            m_lfsr = m_adv(m_lfsr);
            if (sq) m_last = t;
        end
        if (sw) begin
            m_lfsr = (sl == 16'h0) ? 16'h0001 : sl;
            m_last = st;
        end
        req_valid = 1'b1; req_addr = a; req_excl = xo; cfg_excl_mask = mk;
        cfg_seq_mode = sq; cfg_tag_en = en;
        seed_we = sw; seed_lfsr = sl; seed_tag = st;
        @(negedge clk);
        req_valid = 1'b0; seed_we = 1'b0;
    endtask

    task automatic do_seed(input logic [15:0] sl, input logic [3:0] st);
        m_lfsr = (sl == 16'h0) ? 16'h0001 : sl;
        m_last = st;
        seed_we = 1'b1; seed_lfsr = sl; seed_tag = st;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each result against the head of the scoreboard. R8
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (exp_q.size() != 0) begin
                string r;
                logic [63:0] e;
                r = tag_q.pop_front();
                e = exp_q.pop_front();
                check({r, " valid R8"}, {63'h0, rsp_valid}, 64'h1);
                check(r, rsp_data, e);
            end else begin
                check("R8 idle valid", {63'h0, rsp_valid}, 64'h0);
            end
        end
    end

    bit done = 1'b0;
    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state of outputs
        check("R11 rsp_valid", {63'h0, rsp_valid}, 64'h0);
        check("R11 rsp_data", rsp_data, 64'h0);
        @(negedge clk);

        // R11/R4 first draws come from reset generator state
        send(64'h0123_4567_89AB_CDEF, 64'h0, 16'h0, 1'b0, 1'b1, 0, 0, 0, "R11 R4 free");
        send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 1'b0, 1'b1, 0, 0, 0, "R7 ones");
        send(64'h0, 64'h0, 16'h0, 1'b0, 1'b1, 0, 0, 0, "R7 zeros");
        idle(1);

        // R1 only one tag open: operand only, mask only, combined, high bits
        send(64'hA5A5_A5A5_A5A5_A5A5, 64'h0000_0000_0000_FFDF, 16'h0, 1'b0, 1'b1, 0, 0, 0, "R1 operand");
        send(64'h5A5A_5A5A_5A5A_5A5A, 64'h0, 16'hFDFF, 1'b0, 1'b1, 0, 0, 0, "R1 mask");
        send(64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FF00, 16'h00F7, 1'b0, 1'b1, 0, 0, 0, "R1 combined");
        send(64'h0, 64'hFFFF_FFFF_FFFF_0000, 16'h0, 1'b0, 1'b1, 0, 0, 0, "R1 high bits ignored");

        // R3 all excluded, both modes
        send(64'hDEAD_BEEF_0000_1111, 64'hFFFF, 16'h0, 1'b0, 1'b1, 0, 0, 0, "R3 free all excl");
        send(64'hDEAD_BEEF_0000_2222, 64'h00FF, 16'hFF00, 1'b1, 1'b1, 0, 0, 0, "R3 seq all excl");
        send(64'h0, 64'h0, 16'h0, 1'b1, 1'b1, 0, 0, 0, "R3 R6 seq after zero start");

        // R2 disabled: tag zero, no state movement
        send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 1'b1, 1'b0, 0, 0, 0, "R2 disabled seq");
        send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 1'b0, 1'b0, 0, 0, 0, "R2 disabled free");
        send(64'h0, 64'h0, 16'h0, 1'b1, 1'b1, 0, 0, 0, "R2 state frozen");

        // R10 zero seed, then free draw
        do_seed(16'h0000, 4'h7);
        send(64'h0, 64'h0, 16'h0, 1'b0, 1'b1, 0, 0, 0, "R10 zero seed");
        // R6 free mode left stored tag 7 in place
        send(64'h0, 64'h0, 16'h0, 1'b1, 1'b1, 0, 0, 0, "R6 free keeps start");

        // R5 zero offset: start excluded / allowed (seed low nibble 0)
        do_seed(16'h1230, 4'h4);
        send(64'h0, 64'h0, 16'h0070, 1'b1, 1'b1, 0, 0, 0, "R5 zero offset excl start");
        do_seed(16'h4560, 4'h9);
        send(64'h0, 64'h0, 16'h0070, 1'b1, 1'b1, 0, 0, 0, "R5 zero offset allowed start");
        // R5 large offset with wrap
        do_seed(16'h000F, 4'hE);
        send(64'h0, 64'h0, 16'h5555, 1'b1, 1'b1, 0, 0, 0, "R5 offset 15 wrap");
        send(64'h0, 64'h0, 16'h0, 1'b1, 1'b1, 0, 0, 0, "R6 writeback chain");

        // R12 seed in same cycle as a request
        send(64'hCAFE_0000_0000_0001, 64'h0, 16'h0, 1'b1, 1'b1, 1'b1, 16'h8001, 4'h3, "R12 same cycle");
        send(64'h0, 64'h0, 16'h0, 1'b1, 1'b1, 0, 0, 0, "R12 seed wins");

        // R9 R8 back-to-back random traffic
        for (int n = 0; n < 300; n++) begin
            logic [63:0] a;
            logic [63:0] xo;
            logic [15:0] mk;
            a  = {$urandom, $urandom};
            xo = {$urandom, $urandom & $urandom};
            mk = 16'($urandom & $urandom & $urandom);
            if (n % 37 == 5) mk = 16'hFFFF;
            if (n % 53 == 11) do_seed(16'($urandom), 4'($urandom));
            send(a, xo, mk, 1'($urandom), ($urandom % 8) != 0, 0, 0, 0, "R9 R5 R4 random");
        end
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule